// File: doc/BRIEF.md
# Single-Cycle 64-bit Load/Store Execution Core

This block executes one 32-bit instruction word per clock from a small subset of a 64-bit RISC instruction set: register add and subtract, add and subtract with a 12-bit immediate, and doubleword load and store. The word arrives on `instr_word` and is qualified by `instr_valid`. Nothing is fetched or sequenced inside the block. A caller, normally a test harness or a larger fetch unit, presents one word per cycle. The effects of that word are visible after the next rising edge.

The word is split into one of three fixed-position layouts. The register layout and the data-transfer layout use an 11-bit opcode in bits [31:21]. The immediate layout uses a 10-bit opcode in bits [31:22]. Operands come from a file of thirty-one 64-bit registers, and register number 31 is a constant zero. Results go back to the register file or to an internal byte-addressed data memory. Memory accesses use a signed, unscaled byte offset, may start at any byte, and wrap around the end of the array.

Three side interfaces complete the block. `illegal` flags any word that cannot be executed. A combinational debug port reads any register. A byte-wide preload port fills the data memory before or between instructions.

Top module: `mini_ldst_core`

## Requirements
- R1: A valid word whose bits [31:21] equal 1112 is a register add. It writes X[bits 9:5] + X[bits 20:16] into register bits [4:0] at the rising edge that ends the cycle. The word 0x8B150289 adds X20 and X21 into X9.
- R2: A valid word whose bits [31:21] equal 1624 writes X[bits 9:5] − X[bits 20:16] into register bits [4:0]. The result is taken modulo 2^64.
- R3: For a valid word whose bits [31:22] equal 580 (add) or 836 (subtract), the 12-bit field [21:10] is zero-extended to 64 bits. The block writes X[bits 9:5] plus or minus that value into register bits [4:0].
- R4: Register number 31 reads as zero on every read path. Any write aimed at register 31 is discarded.
- R5: A valid word with bits [31:21] = 1986 and bits [11:10] = 00 is a load. It computes the byte address as X[bits 9:5] plus the sign-extended 9-bit field [20:12], with no scaling. It writes the 8 bytes starting there, in little-endian order, into register bits [4:0].
- R6: A valid word with bits [31:21] = 1984 and bits [11:10] = 00 is a store. It writes X[bits 4:0] as 8 little-endian bytes at the address formed as in R5.
- R7: Loads and stores may start at any byte address. Byte addresses are taken modulo MEM_BYTES, which must be a power of two, so an access that runs past the last byte continues at byte 0.
- R8: `illegal` is high in a cycle when `instr_valid` is high and the word matches none of the six opcodes. It is also high for a load or store opcode with bits [11:10] other than 00. Such a word changes no register and no memory byte.
- R9: While `instr_valid` is low, `illegal` is low and the word on `instr_word` changes no register and no memory byte.
- R10: Synchronous reset clears every register to zero and blocks instruction writes. The data memory keeps its contents through reset.
- R11: With `pl_en` high, `pl_byte` is written to memory byte `pl_addr` at the rising edge. If a store in the same cycle writes that byte, the stored value wins.
- R12: `dbg_value` gives the current contents of register `dbg_sel` combinationally.
- R13: Bits [15:10] of a register-layout word (the shift amount) do not affect the add or subtract result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Qualifies `instr_word` for this cycle |
| instr_word | input | 32 | Instruction word to execute |
| illegal | output | 1 | Word cannot be executed; no state changed |
| dbg_sel | input | 5 | Register number for the debug read |
| dbg_value | output | 64 | Contents of register `dbg_sel` |
| pl_en | input | 1 | Preload byte write enable |
| pl_addr | input | $clog2(MEM_BYTES) | Preload byte address |
| pl_byte | input | 8 | Preload byte value |

## Verification
The bench attacks these corner cases:

- Negative offsets are aimed at the offset sign bit. A core that zero-extends it would load from about 512 bytes away.
- An immediate with bit 11 set is aimed at the immediate extension. A core that sign-extends it would add a huge negative number.
- Loads and stores that start at byte 253 expose a core without modulo wrap, which would drop or misplace the top bytes.
- Loads at odd starting bytes expose a core that realigns to 8 bytes or swaps byte order.
- Writes to register 31, followed by reads of it as an operand, catch a core that lets the zero register hold a value.
- Illegal words with a nonzero extension field, and store words left on the bus while `instr_valid` is low, would corrupt registers or memory in a core that ignores the qualifiers.
- A preload and a store hitting the same byte in one cycle show which write wins.

// File: rtl/ldst_pkg.sv
`timescale 1ns/1ps
package ldst_pkg;

  localparam int XW      = 64;
  localparam int RIDX_W  = 5;

  localparam logic [10:0] OPC_ADD  = 11'd1112;
  localparam logic [10:0] OPC_SUB  = 11'd1624;
  localparam logic [10:0] OPC_STUR = 11'd1984;
  localparam logic [10:0] OPC_LDUR = 11'd1986;
  localparam logic [9:0]  OPC_ADDI = 10'd580;
  localparam logic [9:0]  OPC_SUBI = 10'd836;

  typedef enum logic [2:0] {
    K_NONE, K_ADD, K_SUB, K_ADDI, K_SUBI, K_LOAD, K_STORE
  } op_kind_e;

  typedef struct packed {
    op_kind_e          kind;
    logic              bad;
    logic [RIDX_W-1:0] src_a;
    logic [RIDX_W-1:0] src_b;
    logic [RIDX_W-1:0] dst;
    logic [XW-1:0]     konst;
  } dec_t;

  function automatic logic [XW-1:0] zext_imm12(input logic [11:0] v);
    return {{(XW-12){1'b0}}, v};
  endfunction

  function automatic logic [XW-1:0] sext_off9(input logic [8:0] v);
    return {{(XW-9){v[8]}}, v};
  endfunction

  // Arithmetic for all kinds; for memory kinds the result is the byte address.
  function automatic logic [XW-1:0] arith(input op_kind_e k, input logic [XW-1:0] a,
                                          input logic [XW-1:0] b, input logic [XW-1:0] c);
    case (k)
      K_ADD:           return a + b;
      K_SUB:           return a - b;
      K_ADDI:          return a + c;
      K_SUBI:          return a - c;
      K_LOAD, K_STORE: return a + c;
      default:         return '0;
    endcase
  endfunction

endpackage

// File: rtl/ldst_decode.sv
`timescale 1ns/1ps
module ldst_decode
  import ldst_pkg::*;
(
  input  logic        valid,
  input  logic [31:0] word,
  output dec_t        dec
);

  logic [10:0] op11;
  logic [9:0]  op10;
  logic [1:0]  ext2;

  assign op11 = word[31:21];
  assign op10 = word[31:22];
  assign ext2 = word[11:10];

  always_comb begin
    dec       = '0;
    dec.kind  = K_NONE;
    dec.src_a = word[9:5];
    dec.src_b = word[20:16];
    dec.dst   = word[4:0];
    dec.konst = zext_imm12(word[21:10]);
    if (valid) begin
      if (op11 == OPC_ADD) begin
        dec.kind = K_ADD;
      end else if (op11 == OPC_SUB) begin
        dec.kind = K_SUB;
      end else if (op11 == OPC_LDUR || op11 == OPC_STUR) begin
        dec.konst = sext_off9(word[20:12]);
        dec.src_b = word[4:0];
        if (ext2 != 2'b00) begin
          dec.bad = 1'b1;
        end else begin
          dec.kind = (op11 == OPC_LDUR) ? K_LOAD : K_STORE;
        end
      end else if (op10 == OPC_ADDI) begin
        dec.kind = K_ADDI;
      end else if (op10 == OPC_SUBI) begin
        dec.kind = K_SUBI;
      end else begin
        dec.bad = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ldst_regfile.sv
`timescale 1ns/1ps
module ldst_regfile #(
  parameter int NREG = 32,
  parameter int DW   = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [DW-1:0]           wdata,
  input  logic [$clog2(NREG)-1:0] ra_a,
  input  logic [$clog2(NREG)-1:0] ra_b,
  input  logic [$clog2(NREG)-1:0] ra_dbg,
  output logic [DW-1:0]           rd_a,
  output logic [DW-1:0]           rd_b,
  output logic [DW-1:0]           rd_dbg
);

  localparam int IW = $clog2(NREG);
  localparam logic [IW-1:0] ZERO_IDX = IW'(NREG - 1);

  logic [DW-1:0] gpr [0:NREG-2];
  logic          wr_hits_gpr;

  assign wr_hits_gpr = we && (waddr != ZERO_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG - 1; i++) gpr[i] <= '0;
    end else if (wr_hits_gpr) begin
      gpr[waddr] <= wdata;
    end
  end

  assign rd_a   = (ra_a   == ZERO_IDX) ? '0 : gpr[ra_a];
  assign rd_b   = (ra_b   == ZERO_IDX) ? '0 : gpr[ra_b];
  assign rd_dbg = (ra_dbg == ZERO_IDX) ? '0 : gpr[ra_dbg];

  // R1: a write to a real register lands with the presented data
  assert_write_lands_R1: assert property (@(posedge clk) disable iff (rst)
    wr_hits_gpr |=> gpr[$past(waddr)] == $past(wdata));

  // R10: reset leaves the lowest and highest registers cleared
  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> (gpr[0] == '0 && gpr[NREG-2] == '0));

endmodule

// File: rtl/ldst_dmem.sv
`timescale 1ns/1ps
module ldst_dmem #(
  parameter int MEM_BYTES = 256,
  parameter int DW        = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         st_en,
  input  logic [$clog2(MEM_BYTES)-1:0] addr,
  input  logic [DW-1:0]                st_data,
  input  logic                         pl_en,
  input  logic [$clog2(MEM_BYTES)-1:0] pl_addr,
  input  logic [7:0]                   pl_byte,
  output logic [DW-1:0]                ld_data
);

  localparam int AW = $clog2(MEM_BYTES);
  localparam int NB = DW / 8;

  logic [7:0]    bytes_q   [0:MEM_BYTES-1];
  logic [AW-1:0] lane_addr [NB];

  // Lane g sits g bytes above the base; the AW-bit add wraps at the array end.
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane_addr[g]      = addr + AW'(g);
    assign ld_data[8*g +: 8] = bytes_q[lane_addr[g]];
  end

  // The store loop comes after the preload write so a store wins a shared byte.
  always_ff @(posedge clk) begin
    if (pl_en) bytes_q[pl_addr] <= pl_byte;
    if (st_en) begin
      for (int i = 0; i < NB; i++) bytes_q[lane_addr[i]] <= st_data[8*i +: 8];
    end
  end

  // R6: lowest byte of a store lands at the base address
  assert_store_low_byte_R6: assert property (@(posedge clk) disable iff (rst)
    st_en |=> bytes_q[$past(addr)] == $past(st_data[7:0]));

  // R7: highest byte of a store lands at the wrapped top lane
  assert_store_top_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    st_en |=> bytes_q[$past(lane_addr[NB-1])] == $past(st_data[DW-1 -: 8]));

endmodule

// File: rtl/mini_ldst_core.sv
`timescale 1ns/1ps
module mini_ldst_core
  import ldst_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  parameter int NREG      = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         instr_valid,
  input  logic [31:0]                  instr_word,
  output logic                         illegal,
  input  logic [4:0]                   dbg_sel,
  output logic [63:0]                  dbg_value,
  input  logic                         pl_en,
  input  logic [$clog2(MEM_BYTES)-1:0] pl_addr,
  input  logic [7:0]                   pl_byte
);

  localparam int AW = $clog2(MEM_BYTES);

  dec_t          dec;
  logic [XW-1:0] opnd_a, opnd_b, result, ld_data, wr_value;
  logic [AW-1:0] mem_addr;
  logic          reg_we, mem_we, is_load, is_store, is_arith;

  ldst_decode u_decode (
    .valid (instr_valid),
    .word  (instr_word),
    .dec   (dec)
  );

  ldst_regfile #(.NREG(NREG), .DW(XW)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .we     (reg_we),
    .waddr  (dec.dst),
    .wdata  (wr_value),
    .ra_a   (dec.src_a),
    .ra_b   (dec.src_b),
    .ra_dbg (dbg_sel),
    .rd_a   (opnd_a),
    .rd_b   (opnd_b),
    .rd_dbg (dbg_value)
  );

  assign result   = arith(dec.kind, opnd_a, opnd_b, dec.konst);
  assign mem_addr = result[AW-1:0];

  assign is_load  = (dec.kind == K_LOAD);
  assign is_store = (dec.kind == K_STORE);
  assign is_arith = (dec.kind == K_ADD) || (dec.kind == K_SUB) ||
                    (dec.kind == K_ADDI) || (dec.kind == K_SUBI);

  assign reg_we   = !rst && (is_arith || is_load);
  assign mem_we   = !rst && is_store;
  assign wr_value = is_load ? ld_data : result;
  assign illegal  = dec.bad;

  ldst_dmem #(.MEM_BYTES(MEM_BYTES), .DW(XW)) u_dmem (
    .clk     (clk),
    .rst     (rst),
    .st_en   (mem_we),
    .addr    (mem_addr),
    .st_data (opnd_b),
    .pl_en   (pl_en),
    .pl_addr (pl_addr),
    .pl_byte (pl_byte),
    .ld_data (ld_data)
  );

  // R8: a rejected word enables no write
  assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!reg_we && !mem_we));

  // R9: an unqualified word neither flags nor writes
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |-> (!illegal && !reg_we && !mem_we));

endmodule

// File: tb/mini_ldst_core_bench.sv
`timescale 1ns/1ps
module mini_ldst_core_bench;

  localparam int MB = 256;
  localparam int OP_ADD = 1112, OP_SUB = 1624, OP_ST = 1984, OP_LD = 1986;
  localparam int OP_ADDI = 580, OP_SUBI = 836;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic        illegal;
  logic [4:0]  dbg_sel = '0;
  logic [63:0] dbg_value;
  logic        pl_en = 1'b0;
  logic [7:0]  pl_addr = '0;
  logic [7:0]  pl_byte = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [63:0] mr [0:31];
  logic [7:0]  mm [0:MB-1];

  always #10 clk = ~clk;

  mini_ldst_core u_mini_ldst_core (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .illegal(illegal), .dbg_sel(dbg_sel), .dbg_value(dbg_value),
    .pl_en(pl_en), .pl_addr(pl_addr), .pl_byte(pl_byte)
  );

  function automatic logic [31:0] enc_r(int op, int rm, int sh, int rn, int rd);
    return {op[10:0], rm[4:0], sh[5:0], rn[4:0], rd[4:0]};
  endfunction
  function automatic logic [31:0] enc_d(int op, int off, int ext, int rn, int rt);
    return {op[10:0], off[8:0], ext[1:0], rn[4:0], rt[4:0]};
  endfunction
  function automatic logic [31:0] enc_i(int op, int imm, int rn, int rd);
    return {op[9:0], imm[11:0], rn[4:0], rd[4:0]};
  endfunction

  task automatic chk(input logic [63:0] act, input logic [63:0] exp,
                     input string tag, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mload(logic [63:0] ea);
    logic [63:0] v = '0;
    for (int i = 7; i >= 0; i--) v = (v << 8) | 64'(mm[(ea + 64'(i)) % MB]);
    return v;
  endfunction

  task automatic sweep(input string tag);
    for (int r = 0; r < 32; r++) begin
      dbg_sel = 5'(r);
      #0.2;
      chk(dbg_value, (r == 31) ? 64'd0 : mr[r], tag, $sformatf("X%0d", r));
    end
  endtask

  // One clock: drive at the falling edge, check the flag, mirror the edge, compare.
  task automatic step(input bit v, input logic [31:0] w, input bit pe, input int pa,
                      input logic [7:0] pb, input string tag);
    int op11, op10, rn, rm, rd;
    logic [63:0] a, val, ea, sdata;
    longint off;
    bit bad, rwe, swe;
    @(negedge clk);
    instr_valid = v; instr_word = w; pl_en = pe; pl_addr = pa[7:0]; pl_byte = pb;
    #1;
    op11 = int'(w[31:21]); op10 = int'(w[31:22]);
    rn = int'(w[9:5]); rm = int'(w[20:16]); rd = int'(w[4:0]);
    a = (rn == 31) ? 64'd0 : mr[rn];
    off = w[20] ? longint'(w[20:12]) - 512 : longint'(w[20:12]);
    ea = a + 64'(off);
    bad = 0; rwe = 0; swe = 0; val = '0; sdata = (rd == 31) ? 64'd0 : mr[rd];
    if (v) begin
      if (op11 == OP_ADD) begin rwe = 1; val = a + ((rm == 31) ? 64'd0 : mr[rm]); end
      else if (op11 == OP_SUB) begin rwe = 1; val = a - ((rm == 31) ? 64'd0 : mr[rm]); end
      else if (op11 == OP_LD || op11 == OP_ST) begin
        if (w[11:10] != 0) bad = 1;
        else if (op11 == OP_LD) begin rwe = 1; val = mload(ea); end
        else swe = 1;
      end
      else if (op10 == OP_ADDI) begin rwe = 1; val = a + 64'(w[21:10]); end
      else if (op10 == OP_SUBI) begin rwe = 1; val = a - 64'(w[21:10]); end
      else bad = 1;
    end
    chk(64'(illegal), 64'(bad), tag, "illegal flag");
    @(posedge clk);
    if (pe) mm[pa % MB] = pb;
    if (swe) for (int i = 0; i < 8; i++) mm[(ea + 64'(i)) % MB] = sdata[8*i +: 8];
    if (rwe && rd != 31) mr[rd] = val;
    #1;
    instr_valid = 0; pl_en = 0;
    sweep(tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1; instr_valid = 0; pl_en = 0;
    repeat (2) @(posedge clk);
    for (int r = 0; r < 32; r++) mr[r] = '0;
    #1;
    sweep(tag);
    @(negedge clk);
    rst = 0;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 32; r++) mr[r] = '0;
    for (int i = 0; i < MB; i++) mm[i] = '0;
    do_reset("R10");

    // R11: fill all of memory through the preload port
    for (int i = 0; i < MB; i++) begin
      @(negedge clk);
      pl_en = 1; pl_addr = 8'(i); pl_byte = 8'((i * 37 + 5) & 8'hFF);
      @(posedge clk);
      mm[i] = 8'((i * 37 + 5) & 8'hFF);
    end

    step(1, enc_i(OP_ADDI, 4095, 31, 1), 0, 0, 0, "R3");   // bit 11 set, must stay positive
    step(1, enc_i(OP_ADDI, 100, 31, 2), 0, 0, 0, "R3");
    step(1, enc_i(OP_SUBI, 300, 2, 3), 0, 0, 0, "R3");     // goes negative
    step(1, enc_d(OP_LD, 0, 0, 31, 20), 0, 0, 0, "R5");
    step(1, enc_d(OP_LD, 3, 0, 31, 21), 0, 0, 0, "R7");    // unaligned
    chk(64'(enc_r(OP_ADD, 21, 0, 20, 9)), 64'h8B150289, "R1", "encoding");
    step(1, 32'h8B150289, 0, 0, 0, "R1");
    step(1, enc_r(OP_SUB, 20, 0, 3, 10), 0, 0, 0, "R2");
    step(1, enc_r(OP_ADD, 1, 6'h2A, 2, 15), 0, 0, 0, "R13"); // nonzero shift field
    step(1, enc_i(OP_ADDI, 250, 31, 5), 0, 0, 0, "R3");
    step(1, enc_d(OP_LD, 3, 0, 5, 6), 0, 0, 0, "R7");      // wraps past byte 255
    step(1, enc_d(OP_LD, -8, 0, 5, 7), 0, 0, 0, "R5");     // negative offset
    step(1, enc_i(OP_ADDI, 8, 31, 12), 0, 0, 0, "R3");
    chk(64'(enc_d(OP_ST, 240, 0, 10, 9) >> 12) & 64'h1FF, 64'h0F0, "R6", "offset field");
    step(1, enc_d(OP_ST, 240, 0, 12, 9), 0, 0, 0, "R6");
    step(1, enc_d(OP_LD, 240, 0, 12, 13), 0, 0, 0, "R6");
    step(1, enc_d(OP_ST, 3, 0, 5, 10), 0, 0, 0, "R7");     // store wraps
    step(1, enc_d(OP_LD, -3, 0, 31, 14), 0, 0, 0, "R7");
    step(1, enc_d(OP_LD, 0, 0, 31, 16), 0, 0, 0, "R7");
    step(1, 32'h0000_0000, 0, 0, 0, "R8");
    step(1, enc_d(OP_LD, 0, 1, 31, 1), 0, 0, 0, "R8");
    step(1, enc_d(OP_ST, 0, 2, 31, 9), 0, 0, 0, "R8");
    step(1, enc_r(12'h123, 1, 0, 1, 1), 0, 0, 0, "R8");
    step(1, enc_d(OP_LD, 0, 0, 31, 17), 0, 0, 0, "R8");    // memory untouched
    step(1, enc_i(OP_ADDI, 7, 1, 31), 0, 0, 0, "R4");
    step(1, enc_d(OP_LD, 8, 0, 31, 31), 0, 0, 0, "R4");
    step(1, enc_r(OP_ADD, 31, 0, 1, 18), 0, 0, 0, "R4");
    step(0, enc_d(OP_ST, 0, 0, 31, 9), 0, 0, 0, "R9");
    step(0, enc_i(OP_ADDI, 5, 31, 1), 0, 0, 0, "R9");
    step(1, enc_d(OP_LD, 0, 0, 31, 19), 0, 0, 0, "R9");
    step(1, enc_i(OP_ADDI, 100, 31, 22), 0, 0, 0, "R3");
    step(1, enc_d(OP_ST, 0, 0, 22, 9), 1, 100, 8'hAA, "R11"); // same byte: store wins
    step(1, enc_d(OP_LD, 0, 0, 22, 23), 0, 0, 0, "R11");
    step(1, enc_d(OP_ST, 0, 0, 22, 1), 1, 50, 8'h5C, "R11");
    step(1, enc_d(OP_LD, 50, 0, 31, 24), 0, 0, 0, "R11");
    @(negedge clk);
    dbg_sel = 5'd31; #1;
    chk(dbg_value, 64'd0, "R12", "debug X31");
    do_reset("R10");
    step(1, enc_d(OP_LD, 100, 0, 31, 25), 0, 0, 0, "R10");  // memory kept
    for (int n = 0; n < 80; n++) begin
      int k = $urandom_range(0, 6);
      int ra = $urandom_range(0, 31), rb = $urandom_range(0, 31), rc = $urandom_range(0, 31);
      int off = $urandom_range(0, 511) - 256;
      logic [31:0] w;
      case (k)
        0: w = enc_r(OP_ADD, rb, 0, ra, rc);
        1: w = enc_r(OP_SUB, rb, 0, ra, rc);
        2: w = enc_i(OP_ADDI, $urandom_range(0, 4095), ra, rc);
        3: w = enc_i(OP_SUBI, $urandom_range(0, 4095), ra, rc);
        4: w = enc_d(OP_LD, off, 0, ra, rc);
        5: w = enc_d(OP_ST, off, 0, ra, rc);
        default: w = enc_d(OP_LD, off, $urandom_range(1, 3), ra, rc);
      endcase
      step(1, w, 0, 0, 0, "R1");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule